// File: doc/BRIEF.md
# PoE Port Sequencing Controller

This block runs one Power-over-Ethernet sourcing port through its life cycle. The phases are idle, a two-point signature probe, an optional classification step, powered operation with current supervision, and then fault handling or disconnect. It selects the probe voltage band for the analog front end and drives the power-switch enable. It takes digitised port voltage (mV) and current (µA) samples over a valid/ready stream. Straps select midspan or endpoint pacing, classification on or off, and automatic or manual restart after a fault. A status code and one LED report the port condition to the host system.

A sample is consumed only on a cycle where `smp_valid` and `smp_ready` are both high. `smp_ready` is high only in the four sampling phases: low probe, high probe, classification and powered. In every other phase the stream is back-pressured, and the source must hold its sample until ready returns. Every timer counts cycles on which `tick` is high, so the durations scale with the tick rate.

Top module: `poe_port_seq`

## Requirements
- R1: After reset the controller is idle: status 0, `pwr_en` 0, `probe_sel` 0, `smp_ready` 0 and `led` 0. On the first clock where `uvlo` and `port_rst` are both low, it moves from idle to the low detection probe.
- R2: A clock edge that sees `uvlo` high sends the controller to idle from any phase, so `pwr_en` is 0 and status is 0 after that edge. It stays idle while `uvlo` stays high. A `port_rst` pulse has the same effect.
- R3: Detection first drives `probe_sel` = 1 (low probe) and takes one sample, then drives `probe_sel` = 2 (high probe) and takes a second sample. Status reads 1 (detecting) in both probe phases.
- R4: The signature is accepted only when all of these hold: the high-probe voltage exceeds the low-probe voltage by at least 1000 mV; the current rises (i2 > i1); and ΔV·1000 lies between ΔI·23750 and ΔI·26250, both bounds inclusive.
- R5: In endpoint mode (`strap_midspan` = 0), a rejected signature returns the controller to the low probe on the next cycle.
- R6: In midspan mode, a rejected signature holds `smp_ready` low, with status 1, for BACKOFF_TICKS ticks before the low probe starts again.
- R7: If no second sample arrives within DET_TIMEOUT ticks in the high probe, the attempt counts as a rejected signature.
- R8: With `strap_class_en` = 1, an accepted signature leads to classification: `probe_sel` = 3, status 2, and one sample is taken. The sample current selects the class: below 8000 µA gives class 0, below 16000 gives 1, below 25000 gives 2, below 35000 gives 3, and anything higher gives 0. With the strap at 0 the class is 0 and the port powers directly.
- R9: While powered (status 3, `pwr_en` 1), a sample above the current limit of the latched class causes a fault (status 4, `pwr_en` 0). The limits are 400000 µA for class 0, 112000 for class 1, 206000 for class 2 and 400000 for class 3.
- R10: While powered, a clock edge that sees `overcurrent` high causes a fault.
- R11: While powered, DISC_COUNT consecutive samples below DISC_UA µA open the switch and return the controller to the low probe. A sample at or above DISC_UA restarts the count.
- R12: With `strap_auto_restart` = 1, a fault lasts one cycle and then detection restarts. With the strap at 0, the fault holds until `port_rst` is asserted.
- R13: The LED is off when idle and steady on when powered. During detection and classification it follows tick-counter bit LED_SLOW_BIT, and in fault it follows bit LED_FAST_BIT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timer enable; timers and LED count only when high |
| port_rst | input | 1 | Synchronous port reset to idle; clears a manual-restart fault |
| strap_midspan | input | 1 | 1 = midspan pacing (backoff after a rejection), 0 = endpoint |
| strap_class_en | input | 1 | 1 = run classification before power-on |
| strap_auto_restart | input | 1 | 1 = automatic restart after a fault, 0 = manual |
| uvlo | input | 1 | Undervoltage lockout flag |
| overcurrent | input | 1 | Overcurrent flag from the front end |
| smp_valid | input | 1 | Sample stream valid |
| smp_ready | output | 1 | Sample stream ready |
| smp_mv | input | VW | Port voltage sample in mV |
| smp_ua | input | IW | Port current sample in µA |
| probe_sel | output | 2 | 0 off, 1 low probe, 2 high probe, 3 classification band |
| pwr_en | output | 1 | Power-switch enable |
| status | output | 3 | 0 idle, 1 detecting, 2 classifying, 3 power good, 4 fault |
| led | output | 1 | LED drive |

## Verification
The signature check is tried with a table of sample pairs. The pairs sit exactly on each resistance bound and one count past each. Other pairs have a voltage step of exactly 1000 mV and one of 950 mV, and others have falling current, falling voltage, a near-short and a near-open load. This separates an inclusive compare from an exclusive one, and a missing step or sign guard from a working one. Classification is run with currents for class 1, class 2 and no classification. Each is then followed by powered samples just around the class limits, which shows whether the latched class really chooses the limit. Directed sequences separate endpoint retry from midspan backoff and the detection timeout from a normal decision. Others interrupt a run of low-current samples to check the consecutive-sample count, and compare automatic with manual restart.

// File: rtl/poe_seq_pkg.sv
package poe_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_DET_LO, ST_DET_HI, ST_CLASS, ST_POWERED, ST_FAULT, ST_BACKOFF
  } seq_state_e;

  typedef enum logic [2:0] {
    STS_IDLE   = 3'd0,
    STS_DETECT = 3'd1,
    STS_CLASS  = 3'd2,
    STS_PGOOD  = 3'd3,
    STS_FAULT  = 3'd4
  } status_e;

  localparam logic [1:0] PROBE_OFF = 2'd0;
  localparam logic [1:0] PROBE_LO  = 2'd1;
  localparam logic [1:0] PROBE_HI  = 2'd2;
  localparam logic [1:0] PROBE_CLS = 2'd3;
endpackage

// File: rtl/poe_sig_check.sv
module poe_sig_check #(
  parameter int VW          = 16,
  parameter int IW          = 20,
  parameter int MIN_STEP_MV = 1000,
  parameter int R_MIN_OHM   = 23750,
  parameter int R_MAX_OHM   = 26250
) (
  input  logic [VW-1:0] v_lo,
  input  logic [IW-1:0] i_lo,
  input  logic [VW-1:0] v_hi,
  input  logic [IW-1:0] i_hi,
  output logic          accept
);
  localparam int PW = VW + IW + 16;

  logic [VW-1:0] dv;
  logic [IW-1:0] di;
  logic [PW-1:0] v_scaled, lo_bound, hi_bound;
  logic          step_ok, rise_ok;

  always_comb begin
    dv       = v_hi - v_lo;
    di       = i_hi - i_lo;
    step_ok  = (v_hi >= v_lo) && (dv >= VW'(MIN_STEP_MV));
    rise_ok  = (i_hi > i_lo);
    v_scaled = PW'(dv) * PW'(1000);
    lo_bound = PW'(di) * PW'(R_MIN_OHM);
    hi_bound = PW'(di) * PW'(R_MAX_OHM);
    accept   = step_ok && rise_ok && (v_scaled >= lo_bound) && (v_scaled <= hi_bound);
  end
endmodule

// File: rtl/poe_class_decode.sv
module poe_class_decode #(
  parameter int IW      = 20,
  parameter int CLS1_UA = 8000,
  parameter int CLS2_UA = 16000,
  parameter int CLS3_UA = 25000,
  parameter int CLS4_UA = 35000,
  parameter int LIM0_UA = 400000,
  parameter int LIM1_UA = 112000,
  parameter int LIM2_UA = 206000,
  parameter int LIM3_UA = 400000
) (
  input  logic [IW-1:0] meas_ua,
  output logic [1:0]    meas_cls,
  input  logic [1:0]    sel_cls,
  output logic [IW-1:0] limit_ua
);
  always_comb begin
    if (meas_ua < IW'(CLS1_UA))      meas_cls = 2'd0;
    else if (meas_ua < IW'(CLS2_UA)) meas_cls = 2'd1;
    else if (meas_ua < IW'(CLS3_UA)) meas_cls = 2'd2;
    else if (meas_ua < IW'(CLS4_UA)) meas_cls = 2'd3;
    else                             meas_cls = 2'd0;
  end

  always_comb begin
    case (sel_cls)
      2'd1:    limit_ua = IW'(LIM1_UA);
      2'd2:    limit_ua = IW'(LIM2_UA);
      2'd3:    limit_ua = IW'(LIM3_UA);
      default: limit_ua = IW'(LIM0_UA);
    endcase
  end
endmodule

// File: rtl/poe_tick_timer.sv
module poe_tick_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          tick,
  output logic [TW-1:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     count <= '0;
    else if (clear) count <= '0;
    else if (tick)  count <= count + 1'b1;
  end
endmodule

// File: rtl/poe_led.sv
module poe_led import poe_seq_pkg::*; #(
  parameter int SLOW_BIT = 9,
  parameter int FAST_BIT = 7
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    tick,
  input  status_e sts,
  output logic    led
);
  localparam int CW = SLOW_BIT + 1;
  logic [CW-1:0] phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    phase <= '0;
    else if (tick) phase <= phase + 1'b1;
  end

  always_comb begin
    case (sts)
      STS_DETECT, STS_CLASS: led = phase[SLOW_BIT];
      STS_PGOOD:             led = 1'b1;
      STS_FAULT:             led = phase[FAST_BIT];
      default:               led = 1'b0;
    endcase
  end
endmodule

// File: rtl/poe_port_seq.sv
module poe_port_seq import poe_seq_pkg::*; #(
  parameter int VW            = 16,
  parameter int IW            = 20,
  parameter int TW            = 16,
  parameter int MIN_STEP_MV   = 1000,
  parameter int DET_TIMEOUT   = 400,
  parameter int BACKOFF_TICKS = 2100,
  parameter int DISC_UA       = 5000,
  parameter int DISC_COUNT    = 60,
  parameter int LED_SLOW_BIT  = 9,
  parameter int LED_FAST_BIT  = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          port_rst,
  input  logic          strap_midspan,
  input  logic          strap_class_en,
  input  logic          strap_auto_restart,
  input  logic          uvlo,
  input  logic          overcurrent,
  input  logic          smp_valid,
  output logic          smp_ready,
  input  logic [VW-1:0] smp_mv,
  input  logic [IW-1:0] smp_ua,
  output logic [1:0]    probe_sel,
  output logic          pwr_en,
  output logic [2:0]    status,
  output logic          led
);
  localparam int DW = $clog2(DISC_COUNT + 1);

  seq_state_e    state_q, state_d, fail_dest;
  status_e       sts;
  logic [VW-1:0] v1_q;
  logic [IW-1:0] i1_q, limit_ua;
  logic [1:0]    cls_q, meas_cls;
  logic [DW-1:0] low_cnt_q;
  logic [TW-1:0] t_cnt;
  logic          take, sig_ok, low_smp;

  poe_sig_check #(.VW(VW), .IW(IW), .MIN_STEP_MV(MIN_STEP_MV)) u_sig (
    .v_lo(v1_q), .i_lo(i1_q), .v_hi(smp_mv), .i_hi(smp_ua), .accept(sig_ok));

  poe_class_decode #(.IW(IW)) u_cls (
    .meas_ua(smp_ua), .meas_cls(meas_cls), .sel_cls(cls_q), .limit_ua(limit_ua));

  poe_tick_timer #(.TW(TW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .clear(state_d != state_q), .tick(tick), .count(t_cnt));

  poe_led #(.SLOW_BIT(LED_SLOW_BIT), .FAST_BIT(LED_FAST_BIT)) u_led (
    .clk(clk), .rst_n(rst_n), .tick(tick), .sts(sts), .led(led));

  assign smp_ready = (state_q == ST_DET_LO) || (state_q == ST_DET_HI) ||
                     (state_q == ST_CLASS)  || (state_q == ST_POWERED);
  assign take      = smp_valid && smp_ready;
  assign low_smp   = smp_ua < IW'(DISC_UA);
  assign fail_dest = strap_midspan ? ST_BACKOFF : ST_DET_LO;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:   state_d = ST_DET_LO;
      ST_DET_LO: if (take) state_d = ST_DET_HI;
      ST_DET_HI: begin
        if (take) state_d = sig_ok ? (strap_class_en ? ST_CLASS : ST_POWERED) : fail_dest;
        else if (tick && t_cnt == TW'(DET_TIMEOUT - 1)) state_d = fail_dest;
      end
      ST_CLASS:  if (take) state_d = ST_POWERED;
      ST_POWERED: begin
        if (overcurrent || (take && smp_ua > limit_ua)) state_d = ST_FAULT;
        else if (take && low_smp && low_cnt_q == DW'(DISC_COUNT - 1)) state_d = ST_DET_LO;
      end
      ST_FAULT:   if (strap_auto_restart) state_d = ST_DET_LO;
      ST_BACKOFF: if (tick && t_cnt == TW'(BACKOFF_TICKS - 1)) state_d = ST_DET_LO;
      default:    state_d = ST_IDLE;
    endcase
    if (uvlo || port_rst) state_d = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      v1_q      <= '0;
      i1_q      <= '0;
      cls_q     <= 2'd0;
      low_cnt_q <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_DET_LO) begin
        cls_q <= 2'd0;
        if (take) begin
          v1_q <= smp_mv;
          i1_q <= smp_ua;
        end
      end
      if (state_q == ST_CLASS && take) cls_q <= meas_cls;
      if (state_q != ST_POWERED)       low_cnt_q <= '0;
      else if (take)                   low_cnt_q <= low_smp ? low_cnt_q + 1'b1 : '0;
    end
  end

  always_comb begin
    case (state_q)
      ST_DET_LO:  begin probe_sel = PROBE_LO;  sts = STS_DETECT; end
      ST_DET_HI:  begin probe_sel = PROBE_HI;  sts = STS_DETECT; end
      ST_BACKOFF: begin probe_sel = PROBE_OFF; sts = STS_DETECT; end
      ST_CLASS:   begin probe_sel = PROBE_CLS; sts = STS_CLASS;  end
      ST_POWERED: begin probe_sel = PROBE_OFF; sts = STS_PGOOD;  end
      ST_FAULT:   begin probe_sel = PROBE_OFF; sts = STS_FAULT;  end
      default:    begin probe_sel = PROBE_OFF; sts = STS_IDLE;   end
    endcase
  end

  assign pwr_en = (state_q == ST_POWERED);
  assign status = sts;

  // R2: lockout forces the switch off and the controller idle
  a_r2_uvlo_off: assert property (@(posedge clk) disable iff (!rst_n)
    uvlo |=> (!pwr_en && status == STS_IDLE));

  // R3: the low-probe sample moves the probe to the high level
  a_r3_lo_to_hi: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DET_LO && take && !uvlo && !port_rst) |=> (probe_sel == PROBE_HI));

  // R4: a voltage step below the minimum never leads to power
  a_r4_small_step: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DET_HI && take && ({1'b0, smp_mv} < {1'b0, v1_q} + (VW+1)'(MIN_STEP_MV)))
    |=> !pwr_en);

  // R10: the overcurrent flag trips a powered port
  a_r10_oc_trip: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_en && overcurrent && !uvlo && !port_rst) |=> (status == STS_FAULT));

  // R12: a manual-restart fault holds until port reset
  a_r12_manual_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (status == STS_FAULT && !strap_auto_restart && !uvlo && !port_rst) |=> (status == STS_FAULT));
endmodule

// File: tb/poe_port_seq_bench.sv
`timescale 1ns/1ps
module poe_port_seq_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b1;
  logic port_rst = 1'b0, strap_midspan = 1'b0, strap_class_en = 1'b0, strap_auto_restart = 1'b1;
  logic uvlo = 1'b1, overcurrent = 1'b0, smp_valid = 1'b0;
  logic [15:0] smp_mv = '0;
  logic [19:0] smp_ua = '0;
  logic smp_ready, pwr_en, led;
  logic [1:0] probe_sel;
  logic [2:0] status;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  poe_port_seq #(
    .DET_TIMEOUT(20), .BACKOFF_TICKS(10), .DISC_COUNT(3),
    .LED_SLOW_BIT(3), .LED_FAST_BIT(1)
  ) u_poe_port_seq (
    .clk(clk), .rst_n(rst_n), .tick(tick), .port_rst(port_rst),
    .strap_midspan(strap_midspan), .strap_class_en(strap_class_en),
    .strap_auto_restart(strap_auto_restart), .uvlo(uvlo), .overcurrent(overcurrent),
    .smp_valid(smp_valid), .smp_ready(smp_ready), .smp_mv(smp_mv), .smp_ua(smp_ua),
    .probe_sel(probe_sel), .pwr_en(pwr_en), .status(status), .led(led));

  // {accept, v1 mV, i1 uA, v2 mV, i2 uA}
  localparam logic [72:0] VEC [11] = '{
    {1'b1, 16'd2800,  20'd100, 16'd10000, 20'd388},   // 25.0 k
    {1'b1, 16'd2800,  20'd50,  16'd9925,  20'd350},   // exactly lower bound
    {1'b1, 16'd2800,  20'd0,   16'd10150, 20'd280},   // exactly upper bound
    {1'b0, 16'd2800,  20'd50,  16'd9924,  20'd350},   // just below
    {1'b0, 16'd2800,  20'd0,   16'd10151, 20'd280},   // just above
    {1'b0, 16'd2800,  20'd0,   16'd3750,  20'd38},    // 950 mV step
    {1'b1, 16'd2800,  20'd0,   16'd3800,  20'd40},    // exact 1000 mV step
    {1'b0, 16'd2800,  20'd400, 16'd10000, 20'd112},   // falling current
    {1'b0, 16'd2800,  20'd0,   16'd10000, 20'd7200},  // near short
    {1'b0, 16'd2800,  20'd0,   16'd10000, 20'd1},     // near open
    {1'b0, 16'd10000, 20'd100, 16'd2800,  20'd388}    // falling voltage
  };

  logic [72:0] vec_e;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // called at a negedge; returns at the negedge after the handshake edge
  task automatic send(input int mv, input int ua);
    int guard = 0;
    while (!smp_ready && guard < 200) begin
      @(negedge clk);
      guard++;
    end
    smp_valid = 1'b1;
    smp_mv = 16'(mv);
    smp_ua = 20'(ua);
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic pulse_rst();
    port_rst = 1'b1;
    @(negedge clk);
    port_rst = 1'b0;
  endtask

  task automatic power_up();
    pulse_rst();
    send(2800, 100);
    send(10000, 388);
  endtask

  task automatic count_toggles(input int cycles, output int n);
    logic prev = led;
    n = 0;
    for (int k = 0; k < cycles; k++) begin
      @(negedge clk);
      if (led != prev) n++;
      prev = led;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    int n;
    @(negedge clk);
    chk("R1 reset status", int'(status), 0);
    chk("R1 reset pwr_en", int'(pwr_en), 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 idle status", int'(status), 0);
    chk("R1 idle probe", int'(probe_sel), 0);
    chk("R1 idle ready", int'(smp_ready), 0);
    chk("R13 idle led", int'(led), 0);
    chk("R2 uvlo holds idle", int'(status), 0);
    uvlo = 1'b0;
    @(negedge clk);
    chk("R1 leaves idle", int'(status), 1);
    chk("R3 low probe code", int'(probe_sel), 1);

    // signature table, endpoint mode, classification off
    for (int k = 0; k < 11; k++) begin
      vec_e = VEC[k];
      pulse_rst();
      send(int'(vec_e[71:56]), int'(vec_e[55:36]));
      chk("R3 high probe code", int'(probe_sel), 2);
      send(int'(vec_e[35:20]), int'(vec_e[19:0]));
      chk("R4 signature decision pwr_en", int'(pwr_en), int'(vec_e[72]));
      chk("R4 signature decision status", int'(status), vec_e[72] ? 3 : 1);
      if (!vec_e[72]) chk("R5 endpoint immediate retry", int'(probe_sel), 1);
    end

    // R6 midspan backoff
    strap_midspan = 1'b1;
    pulse_rst();
    send(2800, 50);
    send(9924, 350);
    n = 0;
    while (!smp_ready && n < 100) begin
      if (status != 3'd1) chk("R6 backoff status", int'(status), 1);
      n++;
      @(negedge clk);
    end
    chk("R6 backoff length", n, 10);
    chk("R6 back to low probe", int'(probe_sel), 1);
    strap_midspan = 1'b0;

    // R7 detection timeout
    pulse_rst();
    send(2800, 100);
    n = 0;
    while (probe_sel == 2'd2 && n < 100) begin
      n++;
      @(negedge clk);
    end
    chk("R7 timeout length", n, 20);
    chk("R7 retry after timeout", int'(probe_sel), 1);

    // R8/R9 classification class 1
    strap_class_en = 1'b1;
    power_up();
    chk("R8 class status", int'(status), 2);
    chk("R8 class probe", int'(probe_sel), 3);
    send(0, 10000);
    chk("R8 powered after class", int'(status), 3);
    send(0, 50000);
    chk("R9 class1 normal load", int'(status), 3);
    send(0, 120000);
    chk("R9 class1 over limit", int'(status), 4);
    chk("R9 switch off on fault", int'(pwr_en), 0);
    @(negedge clk);
    chk("R12 auto restart", int'(status), 1);

    // class 2
    power_up();
    send(0, 20000);
    send(0, 120000);
    chk("R9 class2 within limit", int'(status), 3);
    send(0, 210000);
    chk("R9 class2 over limit", int'(status), 4);

    // class off -> class 0 limit
    strap_class_en = 1'b0;
    power_up();
    chk("R8 direct power when off", int'(status), 3);
    send(0, 120000);
    chk("R8 class0 limit ignores 120mA", int'(status), 3);
    send(0, 410000);
    chk("R9 class0 over limit", int'(status), 4);

    // R10 overcurrent flag, manual restart R12, fault LED R13
    strap_auto_restart = 1'b0;
    power_up();
    count_toggles(16, n);
    chk("R13 powered led steady", n, 0);
    chk("R13 powered led on", int'(led), 1);
    overcurrent = 1'b1;
    @(negedge clk);
    overcurrent = 1'b0;
    chk("R10 overcurrent fault", int'(status), 4);
    chk("R10 switch off", int'(pwr_en), 0);
    count_toggles(16, n);
    chk("R12 manual fault holds", int'(status), 4);
    chk("R13 fault fast blink", n, 8);
    pulse_rst();
    chk("R12 port reset clears fault", int'(status), 0);
    @(negedge clk);
    chk("R12 detection after reset", int'(status), 1);
    count_toggles(16, n);
    chk("R13 detect slow blink", n, 2);
    strap_auto_restart = 1'b1;

    // R11 disconnect
    power_up();
    send(0, 1000);
    send(0, 1000);
    send(0, 50000);
    send(0, 1000);
    send(0, 1000);
    chk("R11 interrupted run stays powered", int'(status), 3);
    send(0, 1000);
    chk("R11 disconnect status", int'(status), 1);
    chk("R11 disconnect switch off", int'(pwr_en), 0);

    // R2 uvlo while powered
    power_up();
    uvlo = 1'b1;
    @(negedge clk);
    chk("R2 uvlo opens switch", int'(pwr_en), 0);
    chk("R2 uvlo idle", int'(status), 0);
    repeat (5) @(negedge clk);
    chk("R2 uvlo held idle", int'(status), 0);
    uvlo = 1'b0;
    @(negedge clk);
    chk("R2 resume after uvlo", int'(status), 1);

    finish_up();
  end
endmodule